// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip. A serial test clock steers a sixteen-state controller through a mode-select line. Serial data enters on a scan input and leaves on a scan output that has its own output enable. An active-low asynchronous reset returns the controller to its reset state.

A 16-bit instruction register holds the active instruction. Its decode chooses which data register sits between scan input and scan output: the external boundary chain, a 32-bit identification register, or a one-bit bypass register. The decode also says whether the device core runs normally or is under test, and whether the pins are floated or held. The boundary cells are outside the block. The block drives their select, capture, shift and update strobes and takes their serial output back in.

The controller has sixteen states: ST_RESET, ST_IDLE, ST_DR_SELECT, ST_DR_CAPTURE, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPDATE, and the matching ST_IR_SELECT, ST_IR_CAPTURE, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2 and ST_IR_UPDATE. With mode-select at 1 the transitions are: RESET to RESET, IDLE to DR_SELECT, DR_SELECT to IR_SELECT, IR_SELECT to RESET, CAPTURE to EXIT1, SHIFT to EXIT1, EXIT1 to UPDATE, PAUSE to EXIT2, EXIT2 to UPDATE, and UPDATE to DR_SELECT. With mode-select at 0 they are: RESET to IDLE, IDLE to IDLE, DR_SELECT to DR_CAPTURE, IR_SELECT to IR_CAPTURE, CAPTURE to SHIFT, SHIFT to SHIFT, EXIT1 to PAUSE, PAUSE to PAUSE, EXIT2 to SHIFT, and UPDATE to IDLE. The same pairs apply separately to the DR and IR columns.

Top module: `tap_ctrl_top`

## Requirements
- R1: While test_rst_n is low, the controller is in ST_RESET at once: the scan output is disabled and low, core_test_mode, bsr_sel, pins_float and pins_hold are 0, and the identification register is the selected data register. The same holds whenever ST_RESET is entered.
- R2: State changes happen on the rising test-clock edge and follow the transitions listed above. This includes pausing a shift through DR_PAUSE and resuming it through DR_EXIT2 without losing data.
- R3: Five consecutive rising edges with mode_sel high reach ST_RESET from any state, with the identification instruction active.
- R4: In IR_CAPTURE the instruction shift register loads 0x0001, so its bits 1..0 are 01. Shifting is least significant bit first: bit 0 (1) appears first at scan_out, then bit 1 (0).
- R5: A shifted instruction becomes active only at the rising edge that leaves IR_UPDATE. Before that edge, all decoded outputs keep their previous values.
- R6: The opcodes are EXTEST 0xFFE8, IDCODE 0xFFFE, SAMPLE 0xFFF8, HIGHZ 0xFFCF, CLAMP 0xFFEF and BYPASS 0xFFFF. core_test_mode is 1 for EXTEST and HIGHZ and 0 for the others.
- R7: EXTEST and SAMPLE select the boundary chain (bsr_sel=1). IDCODE selects the identification register. HIGHZ, CLAMP and BYPASS select the bypass bit.
- R8: Any other 16-bit code decodes as BYPASS: normal mode, bypass bit selected, pins_float and pins_hold at 0.
- R9: The identification register is 32 bits. It captures ID_VALUE with bit 0 forced to 1 in DR_CAPTURE and shifts out least significant bit first.
- R10: The bypass bit captures 0. It delays the scan input by one shift cycle.
- R11: scan_out and scan_out_en change only on the falling test-clock edge. scan_out_en is 1 exactly during ST_IR_SHIFT and ST_DR_SHIFT. Otherwise scan_out is 0.
- R12: When the boundary chain is selected, bsr_capture, bsr_shift and bsr_update are high in DR_CAPTURE, DR_SHIFT and DR_UPDATE respectively, and bsr_out reaches scan_out. When it is not selected, all three strobes stay low.
- R13: pins_float is 1 only under HIGHZ, and pins_hold is 1 only under CLAMP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| test_clk | input | 1 | Serial test clock |
| test_rst_n | input | 1 | Asynchronous active-low controller reset |
| mode_sel | input | 1 | Mode select that steers the state machine |
| scan_in | input | 1 | Serial test data input |
| scan_out | output | 1 | Serial test data output, updated on the falling edge |
| scan_out_en | output | 1 | Output enable for scan_out |
| bsr_out | input | 1 | Serial output of the external boundary chain |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| core_test_mode | output | 1 | Core is under test (1) or in normal operation (0) |
| pins_float | output | 1 | Float all device outputs |
| pins_hold | output | 1 | Hold outputs at the boundary chain's values |

## Verification
A wrong controller state appears at the ports within one falling edge. The output enable rises or falls in the wrong cycle, or a boundary strobe pulses in the wrong position of a path such as a capture, pause or update sequence. A wrong instruction or decode shows on core_test_mode, bsr_sel and the pin controls as soon as IR_UPDATE is left. The next data shift then exposes the register actually selected, through its capture value (0 for bypass, the identity word, or the chain pattern) and its length. A missed reset, from the asynchronous input or from five mode-select ones, is seen on the same edge as the stale test-mode output and the next identity read.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 16;

    localparam logic [IR_W-1:0] OP_EXTEST = 16'hFFE8;
    localparam logic [IR_W-1:0] OP_IDCODE = 16'hFFFE;
    localparam logic [IR_W-1:0] OP_SAMPLE = 16'hFFF8;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 16'hFFCF;
    localparam logic [IR_W-1:0] OP_CLAMP  = 16'hFFEF;
    localparam logic [IR_W-1:0] OP_BYPASS = 16'hFFFF;

    // Loaded into the instruction shifter in IR capture; bits 1..0 are 01
    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = {{(IR_W-2){1'b0}}, 2'b01};

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SELECT, ST_DR_CAPTURE, ST_DR_SHIFT, ST_DR_EXIT1,
        ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPDATE,
        ST_IR_SELECT, ST_IR_CAPTURE, ST_IR_SHIFT, ST_IR_EXIT1,
        ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPDATE
    } tap_state_t;

    typedef enum logic [1:0] {
        DR_BOUNDARY, DR_IDENT, DR_BYPASS
    } dr_sel_t;

    typedef struct packed {
        dr_sel_t dr;
        logic    test_mode;
        logic    float_pins;
        logic    hold_pins;
    } decode_t;

    function automatic decode_t decode_op(input logic [IR_W-1:0] op);
        decode_t d;
        d = '{dr: DR_BYPASS, test_mode: 1'b0, float_pins: 1'b0, hold_pins: 1'b0};
        case (op)
            OP_EXTEST: begin d.dr = DR_BOUNDARY; d.test_mode = 1'b1; end
            OP_SAMPLE: d.dr = DR_BOUNDARY;
            OP_IDCODE: d.dr = DR_IDENT;
            OP_HIGHZ:  begin d.test_mode = 1'b1; d.float_pins = 1'b1; end
            OP_CLAMP:  d.hold_pins = 1'b1;
            default:   d.dr = DR_BYPASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       upd_dr
);

    tap_state_t next_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= next_state;
    end

    always_comb begin
        unique case (state)
            ST_RESET:      next_state = tms ? ST_RESET     : ST_IDLE;
            ST_IDLE:       next_state = tms ? ST_DR_SELECT : ST_IDLE;
            ST_DR_SELECT:  next_state = tms ? ST_IR_SELECT : ST_DR_CAPTURE;
            ST_DR_CAPTURE: next_state = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_SHIFT:   next_state = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_EXIT1:   next_state = tms ? ST_DR_UPDATE : ST_DR_PAUSE;
            ST_DR_PAUSE:   next_state = tms ? ST_DR_EXIT2  : ST_DR_PAUSE;
            ST_DR_EXIT2:   next_state = tms ? ST_DR_UPDATE : ST_DR_SHIFT;
            ST_DR_UPDATE:  next_state = tms ? ST_DR_SELECT : ST_IDLE;
            ST_IR_SELECT:  next_state = tms ? ST_RESET     : ST_IR_CAPTURE;
            ST_IR_CAPTURE: next_state = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_SHIFT:   next_state = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_EXIT1:   next_state = tms ? ST_IR_UPDATE : ST_IR_PAUSE;
            ST_IR_PAUSE:   next_state = tms ? ST_IR_EXIT2  : ST_IR_PAUSE;
            ST_IR_EXIT2:   next_state = tms ? ST_IR_UPDATE : ST_IR_SHIFT;
            ST_IR_UPDATE:  next_state = tms ? ST_DR_SELECT : ST_IDLE;
            default:       next_state = ST_RESET;
        endcase
    end

    always_comb begin
        in_reset = (state == ST_RESET);
        cap_ir   = (state == ST_IR_CAPTURE);
        sh_ir    = (state == ST_IR_SHIFT);
        upd_ir   = (state == ST_IR_UPDATE);
        cap_dr   = (state == ST_DR_CAPTURE);
        sh_dr    = (state == ST_DR_SHIFT);
        upd_dr   = (state == ST_DR_UPDATE);
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tdi,
    input  logic    in_reset,
    input  logic    capture,
    input  logic    shift,
    input  logic    update,
    output logic    sr_lsb,
    output decode_t dec
);

    logic [IR_W-1:0] shreg;
    logic [IR_W-1:0] active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            active <= OP_IDCODE;
        end else begin
            if (in_reset)    active <= OP_IDCODE;
            else if (update) active <= shreg;
            if (capture)     shreg  <= IR_CAPTURE_PAT;
            else if (shift)  shreg  <= {tdi, shreg[IR_W-1:1]};
        end
    end

    // The reset state presents the identification instruction at once
    always_comb begin
        dec    = in_reset ? decode_op(OP_IDCODE) : decode_op(active);
        sr_lsb = shreg[0];
    end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int               ID_W     = 32,
    parameter logic [ID_W-1:0]  ID_VALUE = 32'h0A57_10C3
)(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tdi,
    input  dr_sel_t sel,
    input  logic    capture,
    input  logic    shift,
    input  logic    bsr_out,
    output logic    dr_lsb
);

    localparam logic [ID_W-1:0] ID_CAPTURE = {ID_VALUE[ID_W-1:1], 1'b1};

    logic [ID_W-1:0] id_reg;
    logic            byp_reg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_reg  <= '0;
            byp_reg <= 1'b0;
        end else if (sel == DR_IDENT) begin
            if (capture)    id_reg <= ID_CAPTURE;
            else if (shift) id_reg <= {tdi, id_reg[ID_W-1:1]};
        end else if (sel == DR_BYPASS) begin
            if (capture)    byp_reg <= 1'b0;
            else if (shift) byp_reg <= tdi;
        end
    end

    always_comb begin
        unique case (sel)
            DR_BOUNDARY: dr_lsb = bsr_out;
            DR_IDENT:    dr_lsb = id_reg[0];
            default:     dr_lsb = byp_reg;
        endcase
    end

endmodule

// File: rtl/tap_ctrl_top.sv
module tap_ctrl_top
    import tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0A57_10C3
)(
    input  logic test_clk,
    input  logic test_rst_n,
    input  logic mode_sel,
    input  logic scan_in,
    output logic scan_out,
    output logic scan_out_en,
    input  logic bsr_out,
    output logic bsr_sel,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic core_test_mode,
    output logic pins_float,
    output logic pins_hold
);

    tap_state_t state;
    logic       in_reset, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
    logic       ir_lsb, dr_lsb;
    decode_t    dec;

    tap_fsm u_fsm (
        .clk      (test_clk),
        .rst_n    (test_rst_n),
        .tms      (mode_sel),
        .state    (state),
        .in_reset (in_reset),
        .cap_ir   (cap_ir),
        .sh_ir    (sh_ir),
        .upd_ir   (upd_ir),
        .cap_dr   (cap_dr),
        .sh_dr    (sh_dr),
        .upd_dr   (upd_dr)
    );

    tap_ir u_ir (
        .clk      (test_clk),
        .rst_n    (test_rst_n),
        .tdi      (scan_in),
        .in_reset (in_reset),
        .capture  (cap_ir),
        .shift    (sh_ir),
        .update   (upd_ir),
        .sr_lsb   (ir_lsb),
        .dec      (dec)
    );

    tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
        .clk      (test_clk),
        .rst_n    (test_rst_n),
        .tdi      (scan_in),
        .sel      (dec.dr),
        .capture  (cap_dr),
        .shift    (sh_dr),
        .bsr_out  (bsr_out),
        .dr_lsb   (dr_lsb)
    );

    always_comb begin
        bsr_sel        = (dec.dr == DR_BOUNDARY);
        bsr_capture    = bsr_sel & cap_dr;
        bsr_shift      = bsr_sel & sh_dr;
        bsr_update     = bsr_sel & upd_dr;
        core_test_mode = dec.test_mode;
        pins_float     = dec.float_pins;
        pins_hold      = dec.hold_pins;
    end

    // Serial output retimed to the falling edge
    always_ff @(negedge test_clk or negedge test_rst_n) begin
        if (!test_rst_n) begin
            scan_out    <= 1'b0;
            scan_out_en <= 1'b0;
        end else begin
            scan_out    <= sh_ir ? ir_lsb : (sh_dr ? dr_lsb : 1'b0);
            scan_out_en <= sh_ir | sh_dr;
        end
    end

endmodule

// File: rtl/tap_checker.sv
module tap_checker
    import tap_pkg::*;
(
    input logic       test_clk,
    input logic       test_rst_n,
    input logic       mode_sel,
    input logic       scan_out_en,
    input logic       core_test_mode,
    input logic       bsr_sel,
    input logic       bsr_capture,
    input logic       bsr_shift,
    input logic       bsr_update,
    input logic       pins_float,
    input logic       pins_hold,
    input tap_state_t state
);

    logic [2:0] ones_cnt;

    always_ff @(posedge test_clk or negedge test_rst_n) begin
        if (!test_rst_n)   ones_cnt <= '0;
        else if (mode_sel) ones_cnt <= (ones_cnt == 3'd5) ? 3'd5 : ones_cnt + 3'd1;
        else               ones_cnt <= '0;
    end

    AST_RESET_IDCODE: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        (state == ST_RESET) |=> (!core_test_mode && !bsr_sel && !pins_float && !pins_hold)); // R1
    AST_FIVE_ONES_RESET: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        (ones_cnt == 3'd5) |-> (state == ST_RESET)); // R3
    AST_IR_HOLDS: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        (state != ST_IR_UPDATE && state != ST_RESET && !(state == ST_IR_SELECT && mode_sel))
        |=> ($stable(core_test_mode) && $stable(bsr_sel) && $stable(pins_float) && $stable(pins_hold))); // R5
    AST_OE_IN_SHIFT: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        scan_out_en |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT)); // R11
    AST_STROBE_ONEHOT: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        $onehot0({bsr_capture, bsr_shift, bsr_update})); // R12
    AST_STROBE_SELECTED: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        (bsr_capture || bsr_shift || bsr_update) |-> bsr_sel); // R12
    AST_FLOAT_IN_TEST: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        pins_float |-> (core_test_mode && !bsr_sel && !pins_hold)); // R13
    AST_HOLD_NORMAL: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        pins_hold |-> (!core_test_mode && !bsr_sel)); // R13

endmodule

bind tap_ctrl_top tap_checker u_chk (
    .test_clk       (test_clk),
    .test_rst_n     (test_rst_n),
    .mode_sel       (mode_sel),
    .scan_out_en    (scan_out_en),
    .core_test_mode (core_test_mode),
    .bsr_sel        (bsr_sel),
    .bsr_capture    (bsr_capture),
    .bsr_shift      (bsr_shift),
    .bsr_update     (bsr_update),
    .pins_float     (pins_float),
    .pins_hold      (pins_hold),
    .state          (state)
);

// File: tb/tb_tap_ctrl_top.sv
`timescale 1ns/1ps
module tb_tap_ctrl_top;

    localparam logic [31:0] BENCH_ID = 32'h1357_9BDE;
    localparam logic [31:0] ID_EXP   = 32'h1357_9BDF;   // bit 0 forced to 1
    localparam logic [7:0]  CHAIN_CAP = 8'hA5;

    logic test_clk = 1'b0;
    logic test_rst_n, mode_sel, scan_in;
    logic scan_out, scan_out_en, bsr_out;
    logic bsr_sel, bsr_capture, bsr_shift, bsr_update;
    logic core_test_mode, pins_float, pins_hold;

    int checks = 0;
    int fails  = 0;

    logic [1:0] exp_q[$];   // {value, care}
    int         req_q[$];

    always #10 test_clk = ~test_clk;   // 50 MHz

    tap_ctrl_top #(.ID_W(32), .ID_VALUE(BENCH_ID)) dut (
        .test_clk(test_clk), .test_rst_n(test_rst_n), .mode_sel(mode_sel),
        .scan_in(scan_in), .scan_out(scan_out), .scan_out_en(scan_out_en),
        .bsr_out(bsr_out), .bsr_sel(bsr_sel), .bsr_capture(bsr_capture),
        .bsr_shift(bsr_shift), .bsr_update(bsr_update),
        .core_test_mode(core_test_mode), .pins_float(pins_float), .pins_hold(pins_hold)
    );

    // External boundary chain model
    logic [7:0] chain = '0;
    logic [7:0] chain_upd = '0;
    always @(posedge test_clk) begin
        if (bsr_capture)    chain <= CHAIN_CAP;
        else if (bsr_shift) chain <= {scan_in, chain[7:1]};
        if (bsr_update)     chain_upd <= chain;
    end
    assign bsr_out = chain[0];

    // Monitor: one expected item per shifted bit
    always @(posedge test_clk) begin : monitor
        logic [1:0] it;
        int         r;
        if (scan_out_en) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 unexpected output enable: actual 1 expected 0");
            end else begin
                it = exp_q.pop_front();
                r  = req_q.pop_front();
                if (it[0]) begin
                    checks++;
                    if (scan_out !== it[1]) begin
                        fails++;
                        $display("FAIL R%0d scan bit: actual %0b expected %0b", r, scan_out, it[1]);
                    end
                end
            end
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input int req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic tms, input logic tdi);
        mode_sel = tms;
        scan_in  = tdi;
        @(posedge test_clk);
        @(negedge test_clk);
        #1;
    endtask

    task automatic shift_bits(input int n, input logic [63:0] din, input logic [63:0] exp,
                              input logic [63:0] care, input int req);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({exp[i], care[i]});
            req_q.push_back(req);
            tick(i == n - 1, din[i]);
        end
    endtask

    task automatic goto_shift_dr();
        tick(1, 0); tick(0, 0); tick(0, 0);
    endtask

    task automatic goto_shift_ir();
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    endtask

    task automatic load_ir(input logic [15:0] op);
        goto_shift_ir();
        shift_bits(16, op, 64'h1, 64'h3, 4);   // R4 capture pattern 01
        tick(1, 0);
        tick(0, 0);
    endtask

    initial begin : watchdog
        #(20 * 100000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : driver
        test_rst_n = 1'b0; mode_sel = 1'b1; scan_in = 1'b0;
        @(negedge test_clk); #1;
        @(negedge test_clk); #1;
        // R1 reset state
        chk(scan_out_en, 0, 1, "oe in reset");
        chk(scan_out, 0, 1, "scan_out in reset");
        chk(core_test_mode, 0, 1, "mode in reset");
        chk(bsr_sel, 0, 1, "bsr_sel in reset");
        chk({pins_float, pins_hold}, 0, 1, "pin controls in reset");
        test_rst_n = 1'b1;
        tick(0, 0);

        // R9 identification register after reset
        goto_shift_dr();
        chk(scan_out_en, 1, 11, "oe in shift-dr");
        shift_bits(32, 0, ID_EXP, 64'hFFFF_FFFF, 9);
        tick(1, 0); tick(0, 0);
        chk(scan_out_en, 0, 11, "oe in idle");
        chk(scan_out, 0, 11, "scan_out in idle");

        // R6 R7 BYPASS, R10 bypass behaviour, R2 pause path
        load_ir(16'hFFFF);
        chk(core_test_mode, 0, 6, "bypass mode");
        chk(bsr_sel, 0, 7, "bypass sel");
        goto_shift_dr();
        exp_q.push_back(2'b01); req_q.push_back(10);   // captured 0
        mode_sel = 0; scan_in = 1;
        @(posedge test_clk); #1;
        chk(scan_out, 0, 11, "held through rising edge");
        @(negedge test_clk); #1;
        chk(scan_out, 1, 10, "bypass one-cycle delay");
        shift_bits(4, 4'b0110, 4'b1101, 4'hF, 10);
        tick(0, 0);
        chk(scan_out_en, 0, 2, "oe in pause-dr");
        tick(0, 0); tick(1, 0); tick(0, 0);
        chk(scan_out_en, 1, 2, "resume through exit2");
        shift_bits(4, 4'b1001, 4'b0010, 4'hF, 2);
        tick(1, 0); tick(0, 0);

        // R5 EXTEST takes effect after update
        goto_shift_ir();
        shift_bits(16, 16'hFFE8, 64'h1, 64'h3, 4);
        chk(core_test_mode, 0, 5, "mode before update");
        tick(1, 0);
        chk(core_test_mode, 0, 5, "mode in update-ir");
        tick(0, 0);
        chk(core_test_mode, 1, 6, "extest test mode");
        chk(bsr_sel, 1, 7, "extest selects chain");

        // R12 boundary strobes and chain path
        tick(1, 0); tick(0, 0);
        chk({bsr_capture, bsr_shift, bsr_update}, 3'b100, 12, "capture strobe");
        tick(0, 0);
        chk({bsr_capture, bsr_shift, bsr_update}, 3'b010, 12, "shift strobe");
        shift_bits(8, 8'h3C, CHAIN_CAP, 8'hFF, 12);
        chk({bsr_capture, bsr_shift, bsr_update}, 3'b000, 12, "exit1 strobes");
        tick(1, 0);
        chk({bsr_capture, bsr_shift, bsr_update}, 3'b001, 12, "update strobe");
        tick(0, 0);
        chk(chain_upd, 8'h3C, 12, "chain updated value");

        // SAMPLE
        load_ir(16'hFFF8);
        chk({core_test_mode, bsr_sel}, 2'b01, 6, "sample normal, chain");   // R6 R7

        // R13 HIGHZ
        load_ir(16'hFFCF);
        chk({core_test_mode, bsr_sel, pins_float, pins_hold}, 4'b1010, 13, "highz controls");
        goto_shift_dr();
        chk(bsr_shift, 0, 12, "no strobe when chain unselected");
        shift_bits(3, 3'b110, 3'b100, 3'h7, 7);
        tick(1, 0); tick(0, 0);

        // CLAMP
        load_ir(16'hFFEF);
        chk({core_test_mode, bsr_sel, pins_float, pins_hold}, 4'b0001, 13, "clamp controls");

        // R8 unknown opcode
        load_ir(16'h1234);
        chk({core_test_mode, bsr_sel, pins_float, pins_hold}, 4'b0000, 8, "unknown decodes as bypass");
        goto_shift_dr();
        shift_bits(3, 3'b011, 3'b110, 3'h7, 8);
        tick(1, 0); tick(0, 0);

        // R3 five ones from shift-dr
        load_ir(16'hFFE8);
        goto_shift_dr();
        exp_q.push_back(2'b00); req_q.push_back(3);
        for (int k = 0; k < 4; k++) tick(1, 0);
        chk(core_test_mode, 1, 3, "still extest after four ones");
        tick(1, 0);
        chk({core_test_mode, bsr_sel}, 2'b00, 3, "reset after five ones");
        tick(0, 0);
        goto_shift_dr();
        shift_bits(32, 0, ID_EXP, 64'hFFFF_FFFF, 3);
        tick(1, 0); tick(0, 0);

        // R1 asynchronous reset during a shift
        load_ir(16'hFFE8);
        goto_shift_dr();
        #3 test_rst_n = 1'b0;
        #1;
        chk({scan_out_en, scan_out, core_test_mode, bsr_sel}, 4'b0000, 1, "async reset");
        @(negedge test_clk); #1;
        test_rst_n = 1'b1;
        tick(0, 0);
        goto_shift_dr();
        shift_bits(32, 0, ID_EXP, 64'hFFFF_FFFF, 1);
        tick(1, 0); tick(0, 0);

        chk(exp_q.size(), 0, 11, "all shifted bits observed");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule